// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel

This block is a single bus-master DMA channel for a disk controller. Software loads the address of a descriptor table and sets the transfer direction and the run bit. Later it clears the run bit and inspects the status. On a run request the channel fetches each 8-byte descriptor through a one-word memory read port. It then hands the data mover one burst request per descriptor, carrying the address, the byte length and the direction. It stops after the descriptor flagged as last.

The status byte combines three kinds of bits. The activity bit is read-only. The interrupt and error bits are cleared by writing one, and two per-drive capability flags are ordinary read/write bits. A device interrupt line and error returns from the memory port and the mover update the status. Software treats a transfer as good when, after stopping, the low three status bits read exactly `100`.

Top module: `bm_dma_channel`

## Requirements
- R1: Registers by byte offset: 0 is the command (bit 0 run, bit 3 direction, all other bits read 0), 2 is the status, 4 is the 32-bit table pointer. Offsets 1, 3, 5, 6 and 7 read 0 and ignore writes. Every register reads 0 after reset.
- R2: Bits 1:0 of the table pointer always read 0, and every descriptor fetch uses a 4-byte aligned address.
- R3: When a command write sets the run bit while it reads 0, fetching starts at the pointer. The word at the descriptor base is the buffer address. The word at base+4 has the byte count in bits 15:0 and the last-descriptor flag in bit 31, and bits 30:16 are ignored. The next descriptor starts at base+8.
- R4: Each descriptor produces exactly one mover request with the descriptor's address and length, where a count of 0 means 65536 bytes. The direction output equals command bit 3 (1 = device to memory).
- R5: Status bit 0 (active) reads 1 from the run request until the mover finishes the last descriptor, then reads 0.
- R6: A command write with bit 0 = 0 halts the channel. From the next cycle no memory or mover request is raised and status bit 0 reads 0.
- R7: A high `dev_irq` sets status bit 2 in the next cycle, whether the channel is active or idle.
- R8: Writing 1 to status bit 1 or bit 2 clears that bit, and writing 0 leaves it. If a set and a clear arrive in the same cycle, the set wins.
- R9: A memory read error or a mover error sets status bit 1, clears bit 0 and stops all further requests.
- R10: After completion or an error, writing run = 1 while the run bit still reads 1 starts nothing. A write of 0 followed by a write of 1 restarts the channel.
- R11: Status bits 5 and 6 are read/write capability flags for drive 0 and drive 1. Status bits 3, 4 and 7 read 0.
- R12: A descriptor chain that completes with a device interrupt and no error reads status bits 2:0 = `100` after the run bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Write data (byte registers use bits 7:0) |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| mem_rd_req | output | 1 | Descriptor word read request, held until answered |
| mem_rd_addr | output | 32 | Descriptor word address |
| mem_rd_valid | input | 1 | Read answer strobe |
| mem_rd_data | input | 32 | Read answer data |
| mem_rd_err | input | 1 | Read answer carries an error |
| mv_req | output | 1 | Burst request to the data mover, held until done |
| mv_addr | output | 32 | Burst buffer address |
| mv_len | output | 17 | Burst length in bytes (1 to 65536) |
| mv_to_mem | output | 1 | Burst direction, 1 = device to memory |
| mv_done | input | 1 | Burst finished strobe |
| mv_err | input | 1 | Burst finished with an error |
| dev_irq | input | 1 | Device interrupt |

## Verification
The channel has no parameters, so the bench builds the one fixed layout: 32-bit addresses, 16-bit counts and a 17-bit length output. Because the byte count is exactly 16 bits, the bench can reach the wrap case in which a zero count becomes a 65536-byte burst. Descriptor chains of random length use random latencies on both ports and pointers that are 4- but not 8-byte aligned. Junk bits are placed in the unused count field, and directed runs cover halts in mid-burst, errors injected on each port, and the set-versus-clear race on the interrupt bit.

// File: rtl/bm_dma_channel.sv
module bm_dma_channel (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_rd_req,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [31:0] mem_rd_data,
  input  logic        mem_rd_err,
  output logic        mv_req,
  output logic [31:0] mv_addr,
  output logic [16:0] mv_len,
  output logic        mv_to_mem,
  input  logic        mv_done,
  input  logic        mv_err,
  input  logic        dev_irq
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CNT, S_MOVE, S_HALT} st_t;

  st_t         state;
  logic        run_q, dir_q, irq_q, err_q, last_q;
  logic [1:0]  cap_q;
  logic [29:0] tab_q, cur_q;
  logic [31:0] buf_addr;
  logic [16:0] buf_len;
  logic        act;

  wire wr_cmd   = reg_wr && reg_addr == 3'd0;
  wire wr_sts   = reg_wr && reg_addr == 3'd2;
  wire wr_ptr   = reg_wr && reg_addr == 3'd4;
  wire go       = wr_cmd && reg_wdata[0] && !run_q;
  wire halt     = wr_cmd && !reg_wdata[0];
  wire mem_ok   = mem_rd_req && mem_rd_valid;
  wire mem_fail = mem_ok && mem_rd_err;
  wire mv_fin   = mv_req && mv_done;
  wire mv_fail  = mv_fin && mv_err;

  assign act         = state == S_ADDR || state == S_CNT || state == S_MOVE;
  assign mem_rd_req  = state == S_ADDR || state == S_CNT;
  assign mem_rd_addr = {cur_q, 2'b00} + ((state == S_CNT) ? 32'd4 : 32'd0);
  assign mv_req      = state == S_MOVE;
  assign mv_addr     = buf_addr;
  assign mv_len      = buf_len;
  assign mv_to_mem   = dir_q;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {28'd0, dir_q, 2'b00, run_q};
      3'd2:    reg_rdata = {25'd0, cap_q, 2'b00, irq_q, err_q, act};
      3'd4:    reg_rdata = {tab_q, 2'b00};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      run_q    <= 1'b0;
      dir_q    <= 1'b0;
      irq_q    <= 1'b0;
      err_q    <= 1'b0;
      last_q   <= 1'b0;
      cap_q    <= 2'b00;
      tab_q    <= '0;
      cur_q    <= '0;
      buf_addr <= '0;
      buf_len  <= '0;
    end else begin
      if (wr_cmd) begin
        run_q <= reg_wdata[0];
        dir_q <= reg_wdata[3];
      end
      if (wr_ptr) tab_q <= reg_wdata[31:2];
      if (wr_sts) cap_q <= reg_wdata[6:5];
      irq_q <= dev_irq | (irq_q & !(wr_sts & reg_wdata[2]));
      err_q <= mem_fail | mv_fail | (err_q & !(wr_sts & reg_wdata[1]));

      if (halt) state <= S_IDLE;
      else if (go) begin
        cur_q <= tab_q;
        state <= S_ADDR;
      end else begin
        case (state)
          S_ADDR: if (mem_ok) begin
            if (mem_rd_err) state <= S_HALT;
            else begin
              buf_addr <= mem_rd_data;
              state    <= S_CNT;
            end
          end
          S_CNT: if (mem_ok) begin
            if (mem_rd_err) state <= S_HALT;
            else begin
              buf_len <= {mem_rd_data[15:0] == 16'd0, mem_rd_data[15:0]};
              last_q  <= mem_rd_data[31];
              state   <= S_MOVE;
            end
          end
          S_MOVE: if (mv_fin) begin
            if (mv_err || last_q) state <= S_HALT;
            else begin
              cur_q <= cur_q + 30'd2;
              state <= S_ADDR;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/bm_dma_channel_chk.sv
module bm_dma_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        mem_rd_req,
  input logic [31:0] mem_rd_addr,
  input logic        mem_rd_valid,
  input logic        mem_rd_err,
  input logic        mv_req,
  input logic [16:0] mv_len,
  input logic        mv_done,
  input logic        mv_err,
  input logic        dev_irq,
  input logic        irq_q,
  input logic        act
);

  p_fetch_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> mem_rd_addr[1:0] == 2'b00);

  p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mv_req |-> (mv_len != 17'd0 && mv_len <= 17'h10000));

  p_one_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mv_req && mem_rd_req));

  p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && !reg_wdata[0]) |=> (!mv_req && !mem_rd_req && !act));

  p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_irq |=> irq_q);

  p_mem_err_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_rd_valid && mem_rd_err) |=> (!act && !mem_rd_req && !mv_req));

  p_mv_err_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_req && mv_done && mv_err) |=> (!act && !mem_rd_req && !mv_req));

endmodule

bind bm_dma_channel bm_dma_channel_chk u_chk (.*);

// File: tb/bm_dma_channel_tb.sv
module bm_dma_channel_tb;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mem_rd_req, mem_rd_valid, mem_rd_err;
  logic [31:0] mem_rd_addr, mem_rd_data;
  logic        mv_req, mv_to_mem, mv_done, mv_err;
  logic [31:0] mv_addr;
  logic [16:0] mv_len;
  logic        dev_irq = 0;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [0:63];
  logic [31:0] lg_addr [0:7];
  logic [16:0] lg_len [0:7];
  logic        lg_dir [0:7];
  int          lg_n = 0;
  bit mem_err_arm = 0, mv_err_arm = 0, mv_stall = 0, finished = 0;

  always #5 clk = ~clk;

  bm_dma_channel u_dut (.*);

  task automatic check(string req, logic [31:0] act_v, logic [31:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic irq_pulse();
    @(negedge clk); dev_irq = 1; @(negedge clk); dev_irq = 0;
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] s;
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd2, s);
      if (!s[0]) begin ok = 1; break; end
    end
  endtask

  function automatic logic [16:0] exp_len(logic [31:0] w);
    return (w[15:0] == 16'd0) ? 17'h10000 : {1'b0, w[15:0]};
  endfunction

  initial begin
    int lat;
    mem_rd_valid = 0; mem_rd_err = 0; mem_rd_data = 0;
    forever begin
      @(negedge clk);
      if (mem_rd_req) begin
        lat = $urandom % 3;
        repeat (lat) @(negedge clk);
        if (mem_rd_req) begin
          mem_rd_valid = 1; mem_rd_err = mem_err_arm; mem_err_arm = 0;
          mem_rd_data = mem[mem_rd_addr[7:2]];
          @(negedge clk); mem_rd_valid = 0; mem_rd_err = 0;
        end
      end
    end
  end

  initial begin
    int lat;
    mv_done = 0; mv_err = 0;
    forever begin
      @(negedge clk);
      if (mv_req && !mv_stall) begin
        lat = $urandom % 4;
        repeat (lat) @(negedge clk);
        if (mv_req && !mv_stall) begin
          if (lg_n < 8) begin
            lg_addr[lg_n] = mv_addr; lg_len[lg_n] = mv_len; lg_dir[lg_n] = mv_to_mem;
          end
          lg_n++;
          mv_done = 1; mv_err = mv_err_arm; mv_err_arm = 0;
          @(negedge clk); mv_done = 0; mv_err = 0;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, base;
    logic [31:0] w0 [0:4];
    logic [31:0] w1 [0:4];
    bit ok, dir;
    int n;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(3'd0, d); check("R1 cmd reset", d, 0);
    rd(3'd2, d); check("R1 status reset", d, 0);
    rd(3'd4, d); check("R1 ptr reset", d, 0);
    wr(3'd1, 32'hFF); rd(3'd1, d); check("R1 offset1", d, 0);
    wr(3'd3, 32'hFF); rd(3'd3, d); check("R1 offset3", d, 0);
    wr(3'd0, 32'hFE); rd(3'd0, d); check("R1 cmd bits", d, 32'h08);
    wr(3'd0, 32'h00);
    wr(3'd4, 32'h12345677); rd(3'd4, d); check("R2 ptr low bits", d, 32'h12345674);

    wr(3'd2, 32'h60); rd(3'd2, d); check("R11 cap both", d, 32'h60);
    wr(3'd2, 32'h20); rd(3'd2, d); check("R11 cap drive0", d, 32'h20);
    wr(3'd2, 32'h98); rd(3'd2, d); check("R11 reserved zero", d, 32'h00);

    irq_pulse(); rd(3'd2, d); check("R7 irq while idle", d[2:0], 3'b100);
    wr(3'd2, 32'h00); rd(3'd2, d); check("R8 write zero keeps", d[2:0], 3'b100);
    wr(3'd2, 32'h04); rd(3'd2, d); check("R8 w1c irq", d[2:0], 3'b000);
    @(negedge clk); reg_wr = 1; reg_addr = 3'd2; reg_wdata = 32'h04; dev_irq = 1;
    @(negedge clk); reg_wr = 0; dev_irq = 0;
    rd(3'd2, d); check("R8 set wins", d[2], 1);
    wr(3'd2, 32'h04);

    for (int t = 0; t < 8; t++) begin
      n = 1 + $urandom % 5;
      dir = $urandom % 2;
      base = {24'd0, 3'd0, 3'($urandom % 8), 2'b00} + 32'd4 * ($urandom % 3);
      for (int i = 0; i < n; i++) begin
        w0[i] = $urandom;
        w1[i] = {(i == n - 1), 15'($urandom), (($urandom % 4) == 0) ? 16'd0 : 16'($urandom)};
        if (t == 0 && i == 0) w1[i][15:0] = 16'd0;
        mem[(base[7:2] + 2 * i) % 64] = w0[i];
        mem[(base[7:2] + 2 * i + 1) % 64] = w1[i];
      end
      lg_n = 0;
      wr(3'd4, base);
      wr(3'd0, {28'd0, dir, 3'b001});
      rd(3'd2, d); check("R5 active after start", d[0], 1);
      wait_idle(ok); check("R5 active clears at end", ok, 1);
      check("R4 one request per descriptor", lg_n, n);
      for (int i = 0; i < n && i < 8; i++) begin
        check("R3 buffer address", lg_addr[i], w0[i]);
        check("R4 length", lg_len[i], exp_len(w1[i]));
        check("R4 direction", lg_dir[i], dir);
      end
      irq_pulse();
      wr(3'd0, 32'h0);
      rd(3'd2, d); check("R12 good completion", d[2:0], 3'b100);
      wr(3'd2, 32'h06); rd(3'd2, d); check("R8 w1c both", d[2:0], 3'b000);
    end

    for (int i = 0; i < 3; i++) begin
      mem[16 + 2 * i] = 32'h1000 * (i + 1);
      mem[17 + 2 * i] = (i == 2) ? 32'h8000_0010 : 32'h0000_0010;
    end
    wr(3'd4, 32'h40);

    lg_n = 0; mem_err_arm = 1;
    wr(3'd0, 32'h1); wait_idle(ok);
    rd(3'd2, d); check("R9 mem error", d[2:0], 3'b010);
    check("R9 no move after mem error", lg_n, 0);
    wr(3'd0, 32'h1); repeat (4) @(negedge clk);
    check("R10 no restart without toggle", mem_rd_req, 0);
    rd(3'd2, d); check("R10 stays idle", d[0], 0);
    wr(3'd2, 32'h02);
    wr(3'd0, 32'h0);

    lg_n = 0; mv_err_arm = 1;
    wr(3'd0, 32'h1); wait_idle(ok);
    rd(3'd2, d); check("R9 mover error", d[2:0], 3'b010);
    check("R9 no further bursts", lg_n, 1);
    wr(3'd0, 32'h0); wr(3'd2, 32'h02);

    lg_n = 0;
    wr(3'd0, 32'h1); rd(3'd2, d); check("R10 restart after toggle", d[0], 1);
    wait_idle(ok); check("R10 restarted chain", lg_n, 3);
    wr(3'd0, 32'h0);

    mv_stall = 1;
    wr(3'd0, 32'h1);
    for (int i = 0; i < 50 && !mv_req; i++) @(negedge clk);
    check("R6 burst pending", mv_req, 1);
    irq_pulse();
    rd(3'd2, d); check("R7 irq while active", d[2:0], 3'b101);
    wr(3'd0, 32'h0);
    check("R6 burst dropped", mv_req, 0);
    check("R6 no fetch", mem_rd_req, 0);
    rd(3'd2, d); check("R6 inactive", d[0], 0);
    mv_stall = 0;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule